// File: doc/BRIEF.md
# Operand-Selecting Carry-Select Adder

This block adds two 34-bit operands and a carry-in. It returns a 34-bit sum and a carry-out. Each operand is assembled by a small front stage before it reaches the adder. A single select input picks, for both operands at once, one of two 32-bit source buses. The high part of that bus (bits 31 down to 22) passes through only while an upper-field enable is active. The top two operand bits are both copies of a per-operand extension input.

The adder core is a carry-select chain. It is split into segments whose widths alternate between five and four bits, starting at the least significant end. The last, most significant segment is whatever width remains, which is two bits at the default width. Each segment forms its result for both possible incoming carries ahead of time. The carry arriving from the segment below then picks one of the two results.

A parameter places an output register behind the adder, so that the block can sit in a pipelined datapath and be tested as a clocked unit. The register has a synchronous active-high reset.

Top module: `csel_operand_adder`

## Requirements
- R1: `{cout, sum}` equals the full 35-bit sum of operand A, operand B and `cin`, for any inputs.
- R2: When `sel` is 0, bits 21..0 of each operand come from that operand's `*_src0` bus. When `sel` is 1, they come from its `*_src1` bus.
- R3: Operand bits 31..22 come from the same selected bus while at least one of `upper_keep_n0` and `upper_keep_n1` is low. When both are high, these bits are zero in both operands.
- R4: Operand A bits 33 and 32 both equal `ext_a`, and operand B bits 33 and 32 both equal `ext_b`.
- R5: `cin` is added at bit 0 of the sum.
- R6: A carry crosses every segment boundary. An all-ones operand plus a carry-in of 1 gives a sum of zero with `cout` = 1.
- R7: The adder is a chain of carry-select segments of widths 5,4,5,4,5,4,5,2 from bit 0 upward. Each segment's result and carry-out equal the sum of its own bits and its incoming carry.
- R8: With `OUT_REG` = 1, `sum` and `cout` change only on a rising `clk` edge. They show the result for the inputs present at that edge.
- R9: While `rst` is high at a rising edge, `sum` and `cout` become zero on that edge, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset, clears the outputs |
| sel | input | 1 | Source choice for both operands: 0 picks src0, 1 picks src1 |
| upper_keep_n0 | input | 1 | Active-low enable for operand bits 31..22 |
| upper_keep_n1 | input | 1 | Second active-low enable for operand bits 31..22 |
| a_src0 | input | 32 | Operand A source bus 0 |
| a_src1 | input | 32 | Operand A source bus 1 |
| b_src0 | input | 32 | Operand B source bus 0 |
| b_src1 | input | 32 | Operand B source bus 1 |
| ext_a | input | 1 | Fill value for operand A bits 33..32 |
| ext_b | input | 1 | Fill value for operand B bits 33..32 |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 34 | Sum, registered when OUT_REG = 1 |
| cout | output | 1 | Carry out of bit 33, registered when OUT_REG = 1 |

## Verification
The assertions check the following on every cycle:
- each segment's selected result against its own local addition;
- the zeroed upper field whenever both enables are high;
- the extension fill of the two top bits;
- the registered result against an addition of the assembled operands one edge earlier;
- the cleared outputs after a reset edge.

Only the bench's scenarios can show that the source choice and the enable combinations reach the result as the requirements state. They also show that a carry ripples through every boundary, and that the outputs hold still between edges. Those properties hold only against a model built from the ports.

// File: rtl/csel_add_pkg.sv
package csel_add_pkg;

  // Width of the segment at position idx when widths alternate wa, wb, ...
  // The last segment is clipped to whatever remains of total.
  function automatic int seg_lo(input int idx, input int total, input int wa, input int wb);
    int lo;
    lo = 0;
    for (int i = 0; i < total; i++) begin
      if (i < idx) lo += ((i % 2) == 0) ? wa : wb;
    end
    return lo;
  endfunction

  function automatic int seg_w(input int idx, input int total, input int wa, input int wb);
    int w;
    int lo;
    w  = ((idx % 2) == 0) ? wa : wb;
    lo = seg_lo(idx, total, wa, wb);
    if (lo + w > total) w = total - lo;
    return w;
  endfunction

  function automatic int seg_count(input int total, input int wa, input int wb);
    int n;
    int pos;
    n   = 0;
    pos = 0;
    for (int i = 0; i < total; i++) begin
      if (pos < total) begin
        pos += ((i % 2) == 0) ? wa : wb;
        n++;
      end
    end
    return n;
  endfunction

endpackage

// File: rtl/csel_operand_sel.sv
module csel_operand_sel #(
  parameter int WIDTH = 34,
  parameter int LOW_W = 22,
  parameter int EXT_W = 2,
  localparam int SRC_W = WIDTH - EXT_W,
  localparam int UP_W  = SRC_W - LOW_W
) (
  input  logic             sel,
  input  logic             keep_upper,
  input  logic [SRC_W-1:0] src0,
  input  logic [SRC_W-1:0] src1,
  input  logic             ext,
  output logic [WIDTH-1:0] op
);

  logic [SRC_W-1:0] picked;
  logic [UP_W-1:0]  upper;

  always_comb begin
    picked = sel ? src1 : src0;
    upper  = picked[SRC_W-1:LOW_W] & {UP_W{keep_upper}};
    op     = {{EXT_W{ext}}, upper, picked[LOW_W-1:0]};
  end

  always_comb begin
    // R3
    upper_mask_chk: assert (keep_upper || (op[SRC_W-1:LOW_W] == '0));
    // R4
    ext_fill_chk: assert ($countones(op[WIDTH-1:SRC_W]) == (ext ? EXT_W : 0));
  end

endmodule

// File: rtl/csel_segment.sv
module csel_segment #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] s,
  output logic         cout
);

  logic [W:0] sum_c0;
  logic [W:0] sum_c1;

  always_comb begin
    sum_c0 = {1'b0, a} + {1'b0, b};
    sum_c1 = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, 1'b1};
    {cout, s} = cin ? sum_c1 : sum_c0;
  end

  always_comb begin
    // R7
    seg_sum_chk: assert ({cout, s} == ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin}));
  end

endmodule

// File: rtl/csel_adder.sv
module csel_adder
  import csel_add_pkg::*;
#(
  parameter int WIDTH = 34,
  parameter int SEG_A = 5,
  parameter int SEG_B = 4,
  localparam int NSEG = seg_count(WIDTH, SEG_A, SEG_B)
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] s,
  output logic             cout
);

  logic [NSEG:0] carry;

  assign carry[0] = cin;

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    localparam int LO = seg_lo(g, WIDTH, SEG_A, SEG_B);
    localparam int SW = seg_w(g, WIDTH, SEG_A, SEG_B);
    csel_segment #(.W(SW)) u_seg (
      .a    (a[LO+SW-1:LO]),
      .b    (b[LO+SW-1:LO]),
      .cin  (carry[g]),
      .s    (s[LO+SW-1:LO]),
      .cout (carry[g+1])
    );
  end

  assign cout = carry[NSEG];

endmodule

// File: rtl/csel_out_stage.sv
module csel_out_stage #(
  parameter int WIDTH   = 34,
  parameter bit OUT_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_sum,
  input  logic             d_cout,
  output logic [WIDTH-1:0] q_sum,
  output logic             q_cout
);

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        q_sum  <= '0;
        q_cout <= 1'b0;
      end else begin
        q_sum  <= d_sum;
        q_cout <= d_cout;
      end
    end
  end else begin : g_pass
    assign q_sum  = d_sum;
    assign q_cout = d_cout;
  end

endmodule

// File: rtl/csel_operand_adder.sv
module csel_operand_adder #(
  parameter int WIDTH   = 34,
  parameter int LOW_W   = 22,
  parameter int EXT_W   = 2,
  parameter int SEG_A   = 5,
  parameter int SEG_B   = 4,
  parameter bit OUT_REG = 1'b1,
  localparam int SRC_W  = WIDTH - EXT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel,
  input  logic             upper_keep_n0,
  input  logic             upper_keep_n1,
  input  logic [SRC_W-1:0] a_src0,
  input  logic [SRC_W-1:0] a_src1,
  input  logic [SRC_W-1:0] b_src0,
  input  logic [SRC_W-1:0] b_src1,
  input  logic             ext_a,
  input  logic             ext_b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);

  logic             keep_upper;
  logic [WIDTH-1:0] op_a;
  logic [WIDTH-1:0] op_b;
  logic [WIDTH-1:0] add_s;
  logic             add_c;

  assign keep_upper = ~upper_keep_n0 | ~upper_keep_n1;

  csel_operand_sel #(.WIDTH(WIDTH), .LOW_W(LOW_W), .EXT_W(EXT_W)) u_sel_a (
    .sel        (sel),
    .keep_upper (keep_upper),
    .src0       (a_src0),
    .src1       (a_src1),
    .ext        (ext_a),
    .op         (op_a)
  );

  csel_operand_sel #(.WIDTH(WIDTH), .LOW_W(LOW_W), .EXT_W(EXT_W)) u_sel_b (
    .sel        (sel),
    .keep_upper (keep_upper),
    .src0       (b_src0),
    .src1       (b_src1),
    .ext        (ext_b),
    .op         (op_b)
  );

  csel_adder #(.WIDTH(WIDTH), .SEG_A(SEG_A), .SEG_B(SEG_B)) u_add (
    .a    (op_a),
    .b    (op_b),
    .cin  (cin),
    .s    (add_s),
    .cout (add_c)
  );

  csel_out_stage #(.WIDTH(WIDTH), .OUT_REG(OUT_REG)) u_out (
    .clk    (clk),
    .rst    (rst),
    .d_sum  (add_s),
    .d_cout (add_c),
    .q_sum  (sum),
    .q_cout (cout)
  );

  if (OUT_REG) begin : g_reg_chk
    logic [WIDTH:0] ref_sum;
    assign ref_sum = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, cin};

    // R1 R8
    sum_latency_chk: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> ({cout, sum} == $past(ref_sum)));

    // R9
    reset_clear_chk: assert property (@(posedge clk)
      rst |=> ((sum == '0) && !cout));
  end

endmodule

// File: tb/csel_operand_adder_bench.sv
`timescale 1ns/1ps
module csel_operand_adder_bench;

  localparam int W  = 34;
  localparam int SW = 32;
  localparam int LW = 22;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sel = 1'b0;
  logic          k0 = 1'b1, k1 = 1'b1;
  logic [SW-1:0] a0 = '0, a1 = '0, b0 = '0, b1 = '0;
  logic          ea = 1'b0, eb = 1'b0, ci = 1'b0;
  logic [W-1:0]  sum;
  logic          cout;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [W:0] exp_q[$];
  string      tag_q[$];
  logic [W:0] last_res = '0;

  always #4 clk = ~clk;

  csel_operand_adder u_csel_operand_adder (
    .clk(clk), .rst(rst), .sel(sel),
    .upper_keep_n0(k0), .upper_keep_n1(k1),
    .a_src0(a0), .a_src1(a1), .b_src0(b0), .b_src1(b1),
    .ext_a(ea), .ext_b(eb), .cin(ci),
    .sum(sum), .cout(cout)
  );

  // Operand as the requirements define it (R2, R3, R4)
  function automatic logic [W-1:0] model_op(input logic s, input logic n0, input logic n1,
                                            input logic [SW-1:0] s0, input logic [SW-1:0] s1,
                                            input logic e);
    logic [SW-1:0] p;
    p = s ? s1 : s0;
    if (n0 && n1) p[SW-1:LW] = '0;
    return {e, e, p};
  endfunction

  task automatic check(input string tag, input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input string tag, input logic s, input logic n0, input logic n1,
                       input logic [SW-1:0] xa0, input logic [SW-1:0] xa1,
                       input logic [SW-1:0] xb0, input logic [SW-1:0] xb1,
                       input logic xea, input logic xeb, input logic xci);
    logic [W-1:0] oa, ob;
    @(negedge clk);
    sel = s; k0 = n0; k1 = n1; a0 = xa0; a1 = xa1; b0 = xb0; b1 = xb1;
    ea = xea; eb = xeb; ci = xci;
    oa = model_op(s, n0, n1, xa0, xa1, xea);
    ob = model_op(s, n0, n1, xb0, xb1, xeb);
    exp_q.push_back({1'b0, oa} + {1'b0, ob} + {{W{1'b0}}, xci});
    tag_q.push_back(tag);
  endtask

  task automatic drain();
    while (exp_q.size() > 0) @(posedge clk);
    #2;
  endtask

  // Monitor: one result per edge after each driven vector
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [W:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {cout, sum}, e);
        last_res = {cout, sum};
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R9: reset with busy inputs
    a0 = 32'hDEAD_BEEF; b0 = 32'h1234_5678; ci = 1'b1; ea = 1'b1; k0 = 1'b0;
    repeat (3) @(posedge clk);
    #1 check("R9 reset state", {cout, sum}, '0);
    @(negedge clk) rst = 1'b0;

    drive("R1 zeros", 1'b0, 1'b1, 1'b1, '0, '0, '0, '0, 1'b0, 1'b0, 1'b0);
    drive("R5 carry-in only", 1'b0, 1'b1, 1'b1, '0, '0, '0, '0, 1'b0, 1'b0, 1'b1);
    drive("R6 all-ones plus cin", 1'b0, 1'b0, 1'b1, '1, '0, '0, '0, 1'b1, 1'b0, 1'b1);
    drive("R6 both all-ones", 1'b1, 1'b1, 1'b0, '0, '1, '0, '1, 1'b1, 1'b1, 1'b1);
    // R6 R7: carries entering each segment boundary
    for (int lo = 5; lo < W - 2; lo += 9) begin
      drive("R6 boundary lo", 1'b0, 1'b0, 1'b0, SW'((64'd1 << lo) - 1), '0, 32'd1, '0, 1'b0, 1'b0, 1'b0);
      drive("R7 boundary hi", 1'b0, 1'b0, 1'b0, SW'((64'd1 << (lo + 4)) - 1), '0, '0, '0, 1'b0, 1'b0, 1'b1);
    end
    drive("R7 into top segment", 1'b0, 1'b0, 1'b0, '1, '0, '0, '0, 1'b0, 1'b0, 1'b1);
    drive("R2 sel0", 1'b0, 1'b0, 1'b0, 32'h0012_3456, 32'h0ABC_DEF0, 32'h0000_1111, 32'h0077_0000, 1'b0, 1'b0, 1'b0);
    drive("R2 sel1", 1'b1, 1'b0, 1'b0, 32'h0012_3456, 32'h0ABC_DEF0, 32'h0000_1111, 32'h0077_0000, 1'b0, 1'b0, 1'b0);
    drive("R3 both high masks", 1'b0, 1'b1, 1'b1, 32'hFFC0_0001, '0, 32'h8040_0002, '0, 1'b0, 1'b0, 1'b0);
    drive("R3 keep via n0", 1'b0, 1'b0, 1'b1, 32'hFFC0_0001, '0, 32'h8040_0002, '0, 1'b0, 1'b0, 1'b0);
    drive("R3 keep via n1", 1'b1, 1'b1, 1'b0, '0, 32'hFFC0_0001, '0, 32'h8040_0002, 1'b0, 1'b0, 1'b0);
    drive("R4 ext a", 1'b0, 1'b1, 1'b1, 32'd7, '0, 32'd9, '0, 1'b1, 1'b0, 1'b0);
    drive("R4 ext b", 1'b0, 1'b1, 1'b1, 32'd7, '0, 32'd9, '0, 1'b0, 1'b1, 1'b0);
    drive("R4 ext both", 1'b0, 1'b1, 1'b1, 32'd7, '0, 32'd9, '0, 1'b1, 1'b1, 1'b1);
    for (int i = 0; i < 300; i++) begin
      drive("R1 random", 1'($urandom), 1'($urandom), 1'($urandom), $urandom, $urandom,
            $urandom, $urandom, 1'($urandom), 1'($urandom), 1'($urandom));
    end
    drain();

    // R8: new inputs do not reach the outputs before the next edge
    drive("R8 one-edge latency", 1'b0, 1'b0, 1'b0, 32'h0F0F_0F0F, '0, 32'h1111_1111, '0, 1'b1, 1'b0, 1'b1);
    #1 check("R8 hold before edge", {cout, sum}, last_res);
    drain();

    // R9: reset in mid-run clears outputs despite active inputs
    @(negedge clk);
    rst = 1'b1; a0 = '1; b0 = '1; k0 = 1'b0; ci = 1'b1;
    @(posedge clk);
    #1 check("R9 mid-run reset", {cout, sum}, '0);
    @(negedge clk) rst = 1'b0;
    drive("R1 after reset", 1'b0, 1'b0, 1'b1, 32'h0000_00FF, '0, 32'h0000_0001, '0, 1'b0, 1'b0, 1'b0);
    drain();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule